// File: doc/BRIEF.md
# Per-Core Miss Stall and Overlap Cycle Profiler

One copy of this block sits beside each core and watches four per-cycle signals: a pipeline-stall flag, a pulse for each instruction-side and data-side first-level miss, and a flag that is high while the shared second-level miss-holding buffer holds at least one request tagged with this core. Over a fixed window of `PT` cycles it builds two counts. The exposed count is the number of cycles in which this core had an off-chip request outstanding. The hidden count is the subset of those cycles in which the core was still doing useful private work, so the miss latency was partly covered.

A cycle counts as useful private work when the pipeline is not stalled, or when an on-chip lookup is still in flight. Each first-level cache has a countdown timer that models the in-flight lookup. A miss loads the timer with the fixed second-level lookup latency `LAT`. The timer then counts down once per cycle and stops at zero. At the end of each window both counts are copied to output registers and a one-cycle done pulse is raised. Both counts then restart from zero. The timers run across window edges and are not cleared there. A later stage reads the two values to estimate slowdown and to choose a partition.

Top module: `core_stall_profiler`

## Requirements
- R1: While `rst_n` is low, and until the first window ends, `vul_cycles` and `ovl_cycles` read 0 and `period_done` is low.
- R2: `vul_cycles` reports how many of the `PT` cycles of the last completed window had `mshr_has_own` high. This includes the last cycle of the window.
- R3: `ovl_cycles` reports how many cycles of the last completed window had `mshr_has_own` high together with either `pipe_stall` low or an L1 lookup pending.
- R4: A cycle with `l1i_miss` high loads the instruction-side timer with `LAT`. The instruction-side lookup then counts as pending for exactly the `LAT` cycles that follow the miss cycle. It does not count as pending in the miss cycle itself.
- R5: The data-side timer behaves the same way on `l1d_miss`, independently of the instruction side. A lookup is pending when either timer is nonzero.
- R6: A timer stops at zero and never wraps. A miss that arrives while a timer is nonzero reloads that timer to `LAT`, which restarts its pending run.
- R7: Windows are back to back, each `PT` cycles long, and the first window begins at the first clock edge after reset. `period_done` is high for exactly one cycle, in the cycle after each window's last cycle. The outputs take their new values in that same cycle. No count carries into the next window. The timers are not cleared at the window edge.
- R8: A window in which `mshr_has_own` is high on every cycle and `pipe_stall` is low on every cycle reports exactly `PT` in both outputs, with no overflow.
- R9: Between done pulses both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_stall | input | 1 | High while the core pipeline is stalled |
| l1i_miss | input | 1 | Pulse: instruction-side L1 miss sent to L2 this cycle |
| l1d_miss | input | 1 | Pulse: data-side L1 miss sent to L2 this cycle |
| mshr_has_own | input | 1 | High while the L2 miss buffer holds at least one entry for this core |
| vul_cycles | output | $clog2(PT+1) | Exposed-miss cycle count of the last window |
| ovl_cycles | output | $clog2(PT+1) | Hidden-miss cycle count of the last window |
| period_done | output | 1 | One-cycle pulse when the two counts are updated |

## Verification
Two things can happen in the same cycle. First, the window-end copy can coincide with an increment on the last cycle of the window. Second, a timer load in that last cycle can coincide with the window restart, so its pending run spills into the next window. The bench places a lone busy, unstalled cycle on the final cycle of a window and expects a count of 1 rather than 0. It also issues a miss on that same final cycle and expects 3 hidden cycles at the start of the following, fully stalled window. A reference model built from the requirements judges each window through a queue of expected results. Further windows cover a reload during a pending run and simultaneous misses on both sides.

// File: rtl/prof_pkg.sv
package prof_pkg;

  typedef enum logic [1:0] {
    TMR_HOLD = 2'd0,
    TMR_LOAD = 2'd1,
    TMR_DEC  = 2'd2
  } tmr_op_e;

  // Next action for a lookup timer: a miss always reloads, zero is a floor.
  function automatic tmr_op_e tmr_op(input logic miss, input logic at_zero);
    if (miss)
      return TMR_LOAD;
    else if (at_zero)
      return TMR_HOLD;
    else
      return TMR_DEC;
  endfunction

  // A miss cycle is hidden when the core keeps doing private work.
  function automatic logic hidden_cycle(input logic busy, input logic stall,
                                        input logic pend);
    return busy & (~stall | pend);
  endfunction

endpackage

// File: rtl/prof_l1_timer.sv
module prof_l1_timer #(
  parameter int LAT = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         miss,
  output logic [$clog2(LAT+1)-1:0]     value,
  output logic                         pending
);
  import prof_pkg::*;

  localparam int TW = $clog2(LAT + 1);

  logic [TW-1:0] cnt;
  tmr_op_e       op;

  assign op = tmr_op(miss, cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case (op)
        TMR_LOAD: cnt <= TW'(LAT);
        TMR_DEC:  cnt <= cnt - 1'b1;
        default:  cnt <= cnt;
      endcase
    end
  end

  assign value   = cnt;
  assign pending = (cnt != '0);

endmodule

// File: rtl/prof_period_ctr.sv
module prof_period_ctr #(
  parameter int PT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  output logic period_end
);
  localparam int PW = (PT > 1) ? $clog2(PT) : 1;

  logic [PW-1:0] phase;

  assign period_end = (phase == PW'(PT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (period_end)
      phase <= '0;
    else
      phase <= phase + 1'b1;
  end

endmodule

// File: rtl/prof_accum.sv
module prof_accum #(
  parameter int PT = 4096
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inc,
  input  logic                      wrap,
  output logic [$clog2(PT+1)-1:0]   snap
);
  localparam int CW = $clog2(PT + 1);

  logic [CW-1:0] count;
  logic [CW-1:0] count_next;

  assign count_next = count + CW'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      snap  <= '0;
    end else if (wrap) begin
      snap  <= count_next;
      count <= '0;
    end else begin
      count <= count_next;
    end
  end

endmodule

// File: rtl/core_stall_profiler.sv
module core_stall_profiler #(
  parameter int PT  = 4096,
  parameter int LAT = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pipe_stall,
  input  logic                     l1i_miss,
  input  logic                     l1d_miss,
  input  logic                     mshr_has_own,
  output logic [$clog2(PT+1)-1:0]  vul_cycles,
  output logic [$clog2(PT+1)-1:0]  ovl_cycles,
  output logic                     period_done
);
  import prof_pkg::*;

  localparam int NUM_L1 = 2;
  localparam int TW     = $clog2(LAT + 1);

  logic [NUM_L1-1:0] l1_miss;
  logic [NUM_L1-1:0] l1_pend;
  logic [TW-1:0]     tmr_val [NUM_L1];
  logic [TW-1:0]     tmr_i;
  logic [TW-1:0]     tmr_d;
  logic              lookup_pend;
  logic              vul_inc;
  logic              ovl_inc;
  logic              period_end;

  assign l1_miss = {l1d_miss, l1i_miss};

  for (genvar g = 0; g < NUM_L1; g++) begin : g_tmr
    prof_l1_timer #(.LAT(LAT)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .miss    (l1_miss[g]),
      .value   (tmr_val[g]),
      .pending (l1_pend[g])
    );
  end

  assign tmr_i       = tmr_val[0];
  assign tmr_d       = tmr_val[1];
  assign lookup_pend = |l1_pend;
  assign vul_inc     = mshr_has_own;
  assign ovl_inc     = hidden_cycle(mshr_has_own, pipe_stall, lookup_pend);

  prof_period_ctr #(.PT(PT)) u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_end (period_end)
  );

  prof_accum #(.PT(PT)) u_vul (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (vul_inc),
    .wrap  (period_end),
    .snap  (vul_cycles)
  );

  prof_accum #(.PT(PT)) u_ovl (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ovl_inc),
    .wrap  (period_end),
    .snap  (ovl_cycles)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      period_done <= 1'b0;
    else
      period_done <= period_end;
  end

endmodule

// File: rtl/prof_chk.sv
module prof_chk #(
  parameter int PT  = 4096,
  parameter int LAT = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     period_done,
  input logic [$clog2(PT+1)-1:0]  vul_cycles,
  input logic [$clog2(PT+1)-1:0]  ovl_cycles,
  input logic                     l1i_miss,
  input logic                     l1d_miss,
  input logic [$clog2(LAT+1)-1:0] tmr_i,
  input logic [$clog2(LAT+1)-1:0] tmr_d
);
  localparam int CW = $clog2(PT + 1);
  localparam int TW = $clog2(LAT + 1);

  p_ovl_le_vul_r3: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |-> (ovl_cycles <= vul_cycles));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |-> (vul_cycles <= CW'(PT)));

  p_load_i_r4: assert property (@(posedge clk) disable iff (!rst_n)
    l1i_miss |=> (tmr_i == TW'(LAT)));

  p_load_d_r5: assert property (@(posedge clk) disable iff (!rst_n)
    l1d_miss |=> (tmr_d == TW'(LAT)));

  p_floor_i_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_i == '0 && !l1i_miss) |=> (tmr_i == '0));

  p_floor_d_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_d == '0 && !l1d_miss) |=> (tmr_d == '0));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |=> !period_done);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(vul_cycles) || !$stable(ovl_cycles)) |-> period_done);

endmodule

bind core_stall_profiler prof_chk #(.PT(PT), .LAT(LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .period_done (period_done),
  .vul_cycles  (vul_cycles),
  .ovl_cycles  (ovl_cycles),
  .l1i_miss    (l1i_miss),
  .l1d_miss    (l1d_miss),
  .tmr_i       (tmr_i),
  .tmr_d       (tmr_d)
);

// File: tb/core_stall_profiler_bench.sv
`timescale 1ns/1ps
module core_stall_profiler_bench;
  localparam int PT  = 16;
  localparam int LAT = 3;
  localparam int CW  = $clog2(PT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_stall = 1'b0, l1i_miss = 1'b0, l1d_miss = 1'b0, mshr_has_own = 1'b0;
  logic [CW-1:0] vul_cycles, ovl_cycles;
  logic period_done;

  always #2.5 clk = ~clk;

  core_stall_profiler #(.PT(PT), .LAT(LAT)) u_core_stall_profiler (
    .clk(clk), .rst_n(rst_n), .pipe_stall(pipe_stall), .l1i_miss(l1i_miss),
    .l1d_miss(l1d_miss), .mshr_has_own(mshr_has_own),
    .vul_cycles(vul_cycles), .ovl_cycles(ovl_cycles), .period_done(period_done));

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int    q_vul[$];
  int    q_ovl[$];
  string q_tag[$];

  int    m_vul = 0, m_ovl = 0, m_ti = 0, m_td = 0, m_phase = 0;
  string cur_tag = "R2";
  int    last_vul = 0, last_ovl = 0;
  int    pushed = 0, seen = 0;

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Driver: one call is one clock cycle; the model follows the requirements.
  task automatic step(input bit st, input bit im, input bit dm, input bit busy);
    bit pend;
    pipe_stall = st; l1i_miss = im; l1d_miss = dm; mshr_has_own = busy;
    pend = (m_ti != 0) || (m_td != 0);
    if (busy) m_vul++;
    if (busy && (!st || pend)) m_ovl++;
    m_ti = im ? LAT : ((m_ti > 0) ? m_ti - 1 : 0);
    m_td = dm ? LAT : ((m_td > 0) ? m_td - 1 : 0);
    m_phase++;
    if (m_phase == PT) begin
      q_vul.push_back(m_vul);
      q_ovl.push_back(m_ovl);
      q_tag.push_back(cur_tag);
      pushed++;
      m_vul = 0; m_ovl = 0; m_phase = 0;
    end
    @(negedge clk);
  endtask

  // Monitor: pops expected items when the done pulse is seen.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (period_done) begin
        seen++;
        if (q_vul.size() == 0) begin
          check("R7", 1, 0, "unexpected done pulse");
        end else begin
          string t;
          int ev, eo;
          ev = q_vul.pop_front(); eo = q_ovl.pop_front(); t = q_tag.pop_front();
          check((t == "R3") ? "R2" : t, int'(vul_cycles), ev, "vul_cycles");
          check(t, int'(ovl_cycles), eo, "ovl_cycles");
          last_vul = ev; last_ovl = eo;
        end
      end else begin
        check("R9", int'(vul_cycles), last_vul, "vul_cycles hold");
        check("R9", int'(ovl_cycles), last_ovl, "ovl_cycles hold");
      end
    end
  end

  initial begin
    #(5.0 * 5000);
    check("R7", 0, 1, "watchdog expired");
    report();
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", int'(vul_cycles), 0, "vul_cycles in reset");
    check("R1", int'(ovl_cycles), 0, "ovl_cycles in reset");
    check("R1", int'(period_done), 0, "period_done in reset");
    rst_n = 1'b1;

    // R2: idle window, then R1 outputs still zero before first done
    cur_tag = "R2";
    for (int c = 0; c < PT; c++) begin
      if (c == PT - 2) begin
        check("R1", int'(vul_cycles), 0, "vul_cycles before first done");
        check("R1", int'(period_done), 0, "done before first window end");
      end
      step(0, 0, 0, 0);
    end
    // R2: five busy stalled cycles -> vul 5, ovl 0
    for (int c = 0; c < PT; c++) step(1, 0, 0, c < 5);
    // R8: full busy, unstalled -> PT, PT
    cur_tag = "R8";
    for (int c = 0; c < PT; c++) step(0, 0, 0, 1);
    // R4: instruction miss at cycle 0, stalled, busy all -> ovl LAT
    cur_tag = "R4";
    for (int c = 0; c < PT; c++) step(1, c == 0, 0, 1);
    // R5: data miss at cycle 2, busy for 10 cycles
    cur_tag = "R5";
    for (int c = 0; c < PT; c++) step(1, 0, c == 2, c < 10);
    // R6: reload at cycle 2, both sides at cycle 8 -> 5 + 3
    cur_tag = "R6";
    for (int c = 0; c < PT; c++) step(1, (c == 0) || (c == 2) || (c == 8), c == 8, 1);
    // R7: lone busy unstalled last cycle plus a miss there
    cur_tag = "R7";
    for (int c = 0; c < PT; c++) step(c != PT - 1, c == PT - 1, 0, c == PT - 1);
    // R7: timers carry over the window edge -> ovl LAT
    for (int c = 0; c < PT; c++) step(1, 0, 0, 1);
    // R3: pseudo-random windows
    cur_tag = "R3";
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < PT; c++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] | lfsr[5], lfsr[3] & lfsr[7] & lfsr[9], lfsr[2] & lfsr[11] & lfsr[8],
             lfsr[4] | lfsr[1]);
      end
    end
    // flush: let the last done pulse be seen
    for (int c = 0; c < 3; c++) step(0, 0, 0, 0);
    check("R7", seen, pushed, "done pulse count");
    check("R7", q_vul.size(), 0, "pending expected items");
    report();
  end

endmodule